// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives control words for a frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a load strobe. All three lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and the edges of the serial clock and the strobe are detected in the system clock domain. On each rising edge of the serial clock, one data bit enters a 24-bit shift register, most significant bit first. Bits shifted in beyond 24 leave through the top of the register, so only the last 24 bits count.

On the rising edge of the load strobe, the shift register contents are copied into one of four holding registers. The two lowest bits of the word pick the register: a reference-divider word, a main-divider word, a function word and an initialization word. A write to the initialization word also copies the same payload into the function word. The reference count is broken out of the reference word as its own field. The two counts of the dual-modulus main divider are broken out of the main-divider word the same way.

Top module: `ser_ctrl_loader`

## Requirements
- R1: Reset clears the four holding registers and the shift register, so a short word shifted in after reset has zeros in every bit position that was not shifted.
- R2: Each rising edge of the synchronized serial clock shifts the register one place towards the MSB and puts the data bit in bit 0, so a word sent MSB first ends up in its natural bit order. A falling edge and a steady level shift nothing.
- R3: A rising edge of the load strobe copies the shift register to the holding register chosen by word bits [1:0]: 00 to the reference word, 01 to the main-divider word, 10 to the function word, 11 to the initialization word.
- R4: A load leaves every holding register other than its destination unchanged, except the function word when the destination is the initialization word (R5).
- R5: A load with bits [1:0] = 11 writes the same 24-bit payload to both the initialization word and the function word.
- R6: When more than 24 bits are shifted before a load, only the last 24 bits shifted are stored.
- R7: ref_count is reference word bits [15:2], a_count is main-divider word bits [7:2], and b_count is main-divider word bits [20:8].
- R8: Shifting without a rising edge of the load strobe changes no holding register.
- R9: Holding the load strobe high loads only once. Words shifted while it stays high, and its falling edge, change nothing until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| ref_word | output | 24 | Reference-divider holding register |
| ncnt_word | output | 24 | Main-divider holding register |
| func_word | output | 24 | Function holding register |
| init_word | output | 24 | Initialization holding register |
| ref_count | output | 14 | Reference count field |
| a_count | output | 6 | Main-divider A count field |
| b_count | output | 13 | Main-divider B count field |

## Verification
Some properties are checked by assertions on every cycle. A shift edge must move the previous register contents up one place and take in the synchronized data bit. With no shift edge the register must hold its contents. No holding register may change unless a strobe edge occurs. A load must reach only its addressed register, and an initialization load must leave the function word equal to the initialization word. Other behaviour can only be shown by the bench's scenarios, because it rests on the serial waveform as a whole. This covers MSB-first ordering across a full word, discarding of surplus leading bits, a strobe held high across a fresh word, and the zeroed shift register after reset.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;

    // Destination codes carried in word bits [1:0]
    typedef enum logic [1:0] {
        DEST_REF  = 2'b00,
        DEST_NCNT = 2'b01,
        DEST_FUNC = 2'b10,
        DEST_INIT = 2'b11
    } dest_e;

    localparam int DEF_WORD_W = 24;
    localparam int DEF_REF_W  = 14;
    localparam int DEF_A_W    = 6;
    localparam int DEF_B_W    = 13;
    localparam int DEF_SYNC_N = 2;

endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [WIDTH-1:0][DEPTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            st_d.chain[i] = {st_q.chain[i][DEPTH-2:0], async_in[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Per line: rising-edge pulse or plain synchronized level
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        if (EDGE_MASK[g]) begin : g_edge
            assign sync_out[g] = st_q.chain[g][STAGES-1] & ~st_q.chain[g][STAGES];
        end else begin : g_level
            assign sync_out[g] = st_q.chain[g][STAGES];
        end
    end

endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

endmodule

// File: rtl/scw_latch_bank.sv
module scw_latch_bank
    import ser_ctrl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] ref_q,
    output logic [WORD_W-1:0] ncnt_q,
    output logic [WORD_W-1:0] func_q,
    output logic [WORD_W-1:0] init_q
);

    typedef struct packed {
        logic [WORD_W-1:0] ref_w;
        logic [WORD_W-1:0] ncnt_w;
        logic [WORD_W-1:0] func_w;
        logic [WORD_W-1:0] init_w;
    } bank_st_t;

    bank_st_t st_d, st_q;
    dest_e    dest;

    assign dest = dest_e'(word_in[1:0]);

    always_comb begin
        st_d = st_q;
        if (load) begin
            unique case (dest)
                DEST_REF:  st_d.ref_w  = word_in;
                DEST_NCNT: st_d.ncnt_w = word_in;
                DEST_FUNC: st_d.func_w = word_in;
                DEST_INIT: begin
                    st_d.init_w = word_in;
                    st_d.func_w = word_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_q  = st_q.ref_w;
    assign ncnt_q = st_q.ncnt_w;
    assign func_q = st_q.func_w;
    assign init_q = st_q.init_w;

endmodule

// File: rtl/ser_ctrl_loader.sv
module ser_ctrl_loader
    import ser_ctrl_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int REF_W  = DEF_REF_W,
    parameter int A_W    = DEF_A_W,
    parameter int B_W    = DEF_B_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [WORD_W-1:0] ref_word,
    output logic [WORD_W-1:0] ncnt_word,
    output logic [WORD_W-1:0] func_word,
    output logic [WORD_W-1:0] init_word,
    output logic [REF_W-1:0]  ref_count,
    output logic [A_W-1:0]    a_count,
    output logic [B_W-1:0]    b_count
);

    localparam int SEL_W = 2;
    localparam int R_LSB = SEL_W;
    localparam int A_LSB = SEL_W;
    localparam int B_LSB = SEL_W + A_W;

    // line order: [2] strobe, [1] serial clock, [0] data
    localparam logic [2:0] EDGE_LINES = 3'b110;

    logic [2:0]        sync_lines;
    logic              dat_bit;
    logic              sclk_rise;
    logic              le_rise;
    logic [WORD_W-1:0] shift_word;

    scw_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_N),
        .EDGE_MASK (EDGE_LINES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_le, ser_clk, ser_dat}),
        .sync_out (sync_lines)
    );

    assign dat_bit   = sync_lines[0];
    assign sclk_rise = sync_lines[1];
    assign le_rise   = sync_lines[2];

    scw_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .bit_in   (dat_bit),
        .word     (shift_word)
    );

    scw_latch_bank #(
        .WORD_W (WORD_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (le_rise),
        .word_in (shift_word),
        .ref_q   (ref_word),
        .ncnt_q  (ncnt_word),
        .func_q  (func_word),
        .init_q  (init_word)
    );

    assign ref_count = ref_word[R_LSB +: REF_W];
    assign a_count   = ncnt_word[A_LSB +: A_W];
    assign b_count   = ncnt_word[B_LSB +: B_W];

endmodule

// File: rtl/scw_chk.sv
module scw_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_rise,
    input logic              le_rise,
    input logic              dat_bit,
    input logic [WORD_W-1:0] shift_word,
    input logic [WORD_W-1:0] ref_word,
    input logic [WORD_W-1:0] ncnt_word,
    input logic [WORD_W-1:0] func_word,
    input logic [WORD_W-1:0] init_word
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_word == '0 && ncnt_word == '0 && func_word == '0
                          && init_word == '0 && shift_word == '0));

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> (shift_word == {$past(shift_word[WORD_W-2:0]), $past(dat_bit)}));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(shift_word));

    // R8
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(ref_word) && $stable(ncnt_word)
                      && $stable(func_word) && $stable(init_word)));

    // R3
    ncnt_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && shift_word[1:0] == 2'b01) |=> (ncnt_word == $past(shift_word)));

    // R4
    ref_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && shift_word[1:0] == 2'b00) |=>
            ($stable(ncnt_word) && $stable(func_word) && $stable(init_word)));

    // R5
    init_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && shift_word[1:0] == 2'b11) |=>
            (func_word == init_word && $stable(ref_word) && $stable(ncnt_word)));

endmodule

bind ser_ctrl_loader scw_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .le_rise    (le_rise),
    .dat_bit    (dat_bit),
    .shift_word (shift_word),
    .ref_word   (ref_word),
    .ncnt_word  (ncnt_word),
    .func_word  (func_word),
    .init_word  (init_word)
);

// File: tb/sim_ser_ctrl_loader.sv
module sim_ser_ctrl_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_le = 1'b0;
    logic [23:0] ref_word, ncnt_word, func_word, init_word;
    logic [13:0] ref_count;
    logic [5:0]  a_count;
    logic [12:0] b_count;

    int total = 0;
    int bad   = 0;

    logic [23:0] m_ref = '0, m_ncnt = '0, m_func = '0, m_init = '0;

    always #4 clk = ~clk;

    ser_ctrl_loader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_le    (ser_le),
        .ref_word  (ref_word),
        .ncnt_word (ncnt_word),
        .func_word (func_word),
        .init_word (init_word),
        .ref_count (ref_count),
        .a_count   (a_count),
        .b_count   (b_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(4);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_cyc(4);
        ser_le = 1'b0;
        wait_cyc(8);
    endtask

    task automatic model_load(input logic [23:0] w);
        case (w[1:0])
            2'b00: m_ref = w;
            2'b01: m_ncnt = w;
            2'b10: m_func = w;
            default: begin m_init = w; m_func = w; end
        endcase
    endtask

    task automatic check_all(input string req);
        chk({req, " ref_word"},  {8'h0, ref_word},  {8'h0, m_ref});
        chk({req, " ncnt_word"}, {8'h0, ncnt_word}, {8'h0, m_ncnt});
        chk({req, " func_word"}, {8'h0, func_word}, {8'h0, m_func});
        chk({req, " init_word"}, {8'h0, init_word}, {8'h0, m_init});
        // R7 fields
        chk("R7 ref_count", {18'h0, ref_count}, {18'h0, m_ref[15:2]});
        chk("R7 a_count",   {26'h0, a_count},   {26'h0, m_ncnt[7:2]});
        chk("R7 b_count",   {19'h0, b_count},   {19'h0, m_ncnt[20:8]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        m_ref = '0; m_ncnt = '0; m_func = '0; m_init = '0;
        wait_cyc(3);
    endtask

    task automatic write_word(input logic [23:0] w);
        send_bits({40'h0, w}, 24);
        pulse_le();
        model_load(w);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        check_all("R1 reset");
    endtask

    // R2 R3 R4 R7: each destination in turn
    task automatic t_each_dest();
        write_word(24'h123458);
        check_all("R3 R4 ref load");
        write_word(24'hA5C3E1);
        check_all("R3 R4 ncnt load");
        write_word(24'h0F0F0E);
        check_all("R3 R4 func load");
        write_word(24'h3C96A4);
        check_all("R2 R3 ref reload");
        write_word(24'h7FFFFD);
        check_all("R7 ncnt all ones fields");
    endtask

    // R5: initialization load mirrors into function word
    task automatic t_init_mirror();
        write_word(24'hC0FFEF);
        check_all("R5 init load");
        chk("R5 func equals init", {8'h0, func_word}, 32'h00C0FFEF);
    endtask

    // R6: over-length word keeps the last 24 bits
    task automatic t_overlength();
        logic [63:0] v;
        v = {34'h0, 6'b101101, 24'h55AA01};
        send_bits(v, 30);
        pulse_le();
        model_load(24'h55AA01);
        check_all("R6 overlength");
    endtask

    // R8: shifting without strobe changes nothing
    task automatic t_no_load();
        send_bits({40'h0, 24'hFEDCBA}, 24);
        wait_cyc(10);
        check_all("R8 shift only");
        // the pending word is loaded by the next strobe
        pulse_le();
        model_load(24'hFEDCBA);
        check_all("R8 pending loaded");
    endtask

    // R9: strobe held high loads once
    task automatic t_le_held();
        send_bits({40'h0, 24'h246809}, 24);
        ser_le = 1'b1;
        wait_cyc(8);
        model_load(24'h246809);
        check_all("R9 first rise loads");
        send_bits({40'h0, 24'h13579D}, 24);
        wait_cyc(8);
        check_all("R9 held high no load");
        ser_le = 1'b0;
        wait_cyc(8);
        check_all("R9 falling edge no load");
        pulse_le();
        model_load(24'h13579D);
        check_all("R9 next rise loads");
    endtask

    // R1: shift register cleared by reset
    task automatic t_reset_shift();
        write_word(24'h00F0F2);
        do_reset();
        check_all("R1 after reset");
        send_bits(64'h1, 2);
        pulse_le();
        m_ncnt = 24'h000001;
        check_all("R1 shift cleared");
    endtask

    initial begin
        t_reset();
        t_each_dest();
        t_init_mirror();
        t_overlength();
        t_no_load();
        t_le_held();
        t_reset_shift();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule